// File: doc/BRIEF.md
# Cycle-Stealing Debug Bus Arbiter

This block decides when a debug access port may use a system bus that a running CPU shares. A debug request arrives with a beat count. The arbiter then watches a per-cycle CPU bus-busy signal and starts the access in the first cycle the CPU leaves the bus idle, so the program is not disturbed. If the CPU keeps the bus busy for the whole timeout window, the arbiter freezes the CPU and takes the bus.

A one-beat access that fits into an idle cycle never freezes the CPU. A longer access freezes the CPU from its second beat until it ends. This holds even when the first beat landed in an idle cycle. When the CPU is halted in debug mode, the access is granted at once, the timeout does not count, and no freeze is applied. Each finished access gives a single-cycle done pulse.

The request side is a valid/ready handshake. A request is taken on a clock edge where valid and ready are both high. Ready is high only while no access is pending or running, so the port waits with valid held and its length stable. A new request may be taken in the same cycle as the done pulse of the previous one. Grant, freeze and done are plain control pins with no back-pressure.

Top module: `dbg_bus_arbiter`

## Requirements
- R1: After reset, req_ready is 1 and bus_grant, cpu_freeze and acc_done are 0.
- R2: While the CPU is running and the bus is busy, and the timeout has not expired, bus_grant stays 0. The first beat is granted, combinationally, in the first cycle after acceptance in which cpu_bus_busy is 0.
- R3: A one-beat access whose beat falls in an idle bus cycle never asserts cpu_freeze.
- R4: A multi-beat access that starts in an idle cycle asserts cpu_freeze from the cycle after its first beat through its last beat. cpu_freeze is 0 in the cycle after the last beat.
- R5: Count the waiting cycles after acceptance from 0. If cycles 0 to 127 are all busy, cpu_freeze and the first beat come in cycle 128. cpu_freeze then stays high over every beat. If cycle 127 is idle, the access takes that cycle normally.
- R6: While cpu_halted is 1, the first beat is granted in the first cycle after acceptance, whatever cpu_bus_busy shows. cpu_freeze stays 0.
- R7: The timeout count restarts from zero with every accepted request.
- R8: acc_done is high for exactly one cycle: the cycle after the last beat.
- R9: req_ready is 0 from the cycle after acceptance until the done cycle, so only one request is held at a time.
- R10: req_len gives the number of beats. A value of 0 is treated as 1.
- R11: bus_grant is high for exactly the number of beats, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Debug access request valid |
| req_ready | output | 1 | Arbiter can take a request |
| req_len | input | LEN_W | Access length in beats (0 means 1) |
| cpu_bus_busy | input | 1 | CPU uses the bus in this cycle |
| cpu_halted | input | 1 | CPU is halted in debug mode |
| bus_grant | output | 1 | Debug access owns the bus this cycle (one beat) |
| cpu_freeze | output | 1 | Stall the CPU |
| acc_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The assertions assume three things about the inputs. cpu_halted does not change while an access is pending or running. A frozen CPU gives up the bus. req_len is stable while req_valid waits. The stimulus keeps cpu_halted fixed for the whole of each request. It changes cpu_bus_busy only at the falling edge, with exactly one idle cycle placed at a chosen wait position or none at all. It drops req_valid right after acceptance, so no second request overlaps a running one.

// File: rtl/dbgarb_pkg.sv
package dbgarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_BURST = 2'd2
  } arb_state_t;
endpackage

// File: rtl/dbgarb_wait_timer.sv
// Counts busy waiting cycles; flags the last allowed one and saturates there.
module dbgarb_wait_timer #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expired
);
  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear)                  cnt_q <= '0;
    else if (step && cnt_q != LAST)  cnt_q <= cnt_q + CW'(1);
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/dbgarb_beat_counter.sv
// Holds the number of beats still owed to the debug access.
module dbgarb_beat_counter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - LEN_W'(1);
  end

  assign last = (left_q == LEN_W'(1));
endmodule

// File: rtl/dbg_bus_arbiter.sv
module dbg_bus_arbiter
  import dbgarb_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int TIMEOUT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cpu_bus_busy,
  input  logic             cpu_halted,
  output logic             bus_grant,
  output logic             cpu_freeze,
  output logic             acc_done
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  arb_state_t       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic             freeze_q, freeze_d;
  logic             done_q, done_d;

  logic             tmr_clear, tmr_step, tmr_expired;
  logic             bc_load, bc_dec, bc_last;
  logic [LEN_W-1:0] bc_val;
  logic             take_now, single;

  dbgarb_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .step    (tmr_step),
    .expired (tmr_expired)
  );

  dbgarb_beat_counter #(.LEN_W(LEN_W)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bc_load),
    .load_val (bc_val),
    .dec      (bc_dec),
    .last     (bc_last)
  );

  assign take_now = cpu_halted || !cpu_bus_busy;
  assign single   = (len_q == ONE);

  always_comb begin
    state_d   = state_q;
    freeze_d  = freeze_q;
    done_d    = 1'b0;
    bus_grant = 1'b0;
    tmr_clear = 1'b0;
    tmr_step  = 1'b0;
    bc_load   = 1'b0;
    bc_dec    = 1'b0;
    bc_val    = len_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (req_valid) begin
          state_d   = ARB_WAIT;
          tmr_clear = 1'b1;
        end
      end
      ARB_WAIT: begin
        if (take_now) begin
          bus_grant = 1'b1;
          if (single) begin
            state_d = ARB_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d  = ARB_BURST;
            bc_load  = 1'b1;
            bc_val   = len_q - ONE;
            freeze_d = !cpu_halted;
          end
        end else if (tmr_expired) begin
          state_d  = ARB_BURST;
          bc_load  = 1'b1;
          bc_val   = len_q;
          freeze_d = 1'b1;
        end else begin
          tmr_step = 1'b1;
        end
      end
      ARB_BURST: begin
        bus_grant = 1'b1;
        bc_dec    = 1'b1;
        if (bc_last) begin
          state_d  = ARB_IDLE;
          freeze_d = 1'b0;
          done_d   = 1'b1;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ARB_IDLE;
      len_q    <= ONE;
      freeze_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      freeze_q <= freeze_d;
      done_q   <= done_d;
      if (state_q == ARB_IDLE && req_valid)
        len_q <= (req_len == '0) ? ONE : req_len;
    end
  end

  assign req_ready  = (state_q == ARB_IDLE);
  assign cpu_freeze = freeze_q;
  assign acc_done   = done_q;
endmodule

// File: rtl/dbg_bus_arbiter_chk.sv
module dbg_bus_arbiter_chk #(
  parameter int TIMEOUT = 128
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic cpu_bus_busy,
  input logic cpu_halted,
  input logic bus_grant,
  input logic cpu_freeze,
  input logic acc_done
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  wait_cnt <= '0;
    else if (!req_ready && !bus_grant) begin
      if (wait_cnt != CW'(TIMEOUT))              wait_cnt <= wait_cnt + CW'(1);
    end else                                     wait_cnt <= '0;
  end

  // R5: never more than TIMEOUT waiting cycles before a beat
  a_r5_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_grant) |-> (wait_cnt < CW'(TIMEOUT)));

  // R2: a beat in a busy cycle of a running CPU needs the freeze
  a_r2_busy_beat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && cpu_bus_busy && !cpu_halted) |-> cpu_freeze);

  a_r4_freeze_inside_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_freeze |-> bus_grant);

  a_r4_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> !cpu_freeze);

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  a_r8_done_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> ($past(bus_grant) && !bus_grant));

  a_r9_no_accept_during_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !req_ready);
endmodule

bind dbg_bus_arbiter dbg_bus_arbiter_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .cpu_bus_busy (cpu_bus_busy),
  .cpu_halted   (cpu_halted),
  .bus_grant    (bus_grant),
  .cpu_freeze   (cpu_freeze),
  .acc_done     (acc_done)
);

// File: tb/dbg_bus_arbiter_test.sv
module dbg_bus_arbiter_test;
  localparam int LEN_W = 4;
  localparam int TMO   = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [LEN_W-1:0] req_len = '0;
  logic             cpu_bus_busy = 1'b0;
  logic             cpu_halted = 1'b0;
  logic             bus_grant;
  logic             cpu_freeze;
  logic             acc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dbg_bus_arbiter #(.LEN_W(LEN_W), .TIMEOUT(TMO)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_len      (req_len),
    .cpu_bus_busy (cpu_bus_busy),
    .cpu_halted   (cpu_halted),
    .bus_grant    (bus_grant),
    .cpu_freeze   (cpu_freeze),
    .acc_done     (acc_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int cyc, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: cycle %0d actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // One request; busy every waiting cycle except idle_at (none if >= TMO).
  task automatic run_req(input int len, input int idle_at, input bit halted, input string req);
    int nbeats = (len == 0) ? 1 : len;
    bit forced = !halted && idle_at >= TMO;
    int start  = halted ? 0 : (forced ? TMO : idle_at);
    int last_w = start + nbeats + 2;
    int bad_w[4] = '{-1, -1, -1, -1};
    int bad_a[4] = '{0, 0, 0, 0};
    int bad_e[4] = '{0, 0, 0, 0};
    cpu_halted   = halted;
    cpu_bus_busy = 1'b1;
    req_len      = LEN_W'(len);
    req_valid    = 1'b1;
    #1;
    check(req_ready == 1'b1, req, "ready before accept", -1, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w <= last_w; w++) begin
      bit eg, ef, ed, er;
      cpu_bus_busy = halted ? 1'b1 : (w != idle_at);
      #1;
      eg = (w >= start) && (w < start + nbeats);
      ef = halted ? 1'b0 : forced ? eg : ((w > start) && (w < start + nbeats));
      ed = (w == start + nbeats);
      er = (w >= start + nbeats);
      if (bus_grant  != eg && bad_w[0] < 0) begin bad_w[0] = w; bad_a[0] = bus_grant;  bad_e[0] = eg; end
      if (cpu_freeze != ef && bad_w[1] < 0) begin bad_w[1] = w; bad_a[1] = cpu_freeze; bad_e[1] = ef; end
      if (acc_done   != ed && bad_w[2] < 0) begin bad_w[2] = w; bad_a[2] = acc_done;   bad_e[2] = ed; end
      if (req_ready  != er && bad_w[3] < 0) begin bad_w[3] = w; bad_a[3] = req_ready;  bad_e[3] = er; end
      @(negedge clk);
    end
    cpu_bus_busy = 1'b0;
    cpu_halted   = 1'b0;
    check(bad_w[0] < 0, req, "grant (R11)",  bad_w[0], bad_a[0], bad_e[0]);
    check(bad_w[1] < 0, req, "freeze",       bad_w[1], bad_a[1], bad_e[1]);
    check(bad_w[2] < 0, req, "done (R8)",    bad_w[2], bad_a[2], bad_e[2]);
    check(bad_w[3] < 0, req, "ready (R9)",   bad_w[3], bad_a[3], bad_e[3]);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1,  "R1", "ready",  0, int'(req_ready), 1);
    check(bus_grant == 1'b0,  "R1", "grant",  0, int'(bus_grant), 0);
    check(cpu_freeze == 1'b0, "R1", "freeze", 0, int'(cpu_freeze), 0);
    check(acc_done == 1'b0,   "R1", "done",   0, int'(acc_done), 0);
  endtask

  task automatic t_single_idle();
    run_req(1, 0, 1'b0, "R3");
    run_req(1, 5, 1'b0, "R2");
  endtask

  task automatic t_multi_idle();
    run_req(4, 3, 1'b0, "R4");
  endtask

  task automatic t_timeout();
    run_req(2, 500, 1'b0, "R5");
  endtask

  task automatic t_boundary();
    run_req(1, TMO - 1, 1'b0, "R5");
    run_req(1, TMO, 1'b0, "R5");
  endtask

  task automatic t_halted();
    run_req(3, 500, 1'b1, "R6");
  endtask

  task automatic t_restart();
    run_req(2, 100, 1'b0, "R7");
    run_req(1, TMO - 1, 1'b0, "R7");
  endtask

  task automatic t_zero_len();
    run_req(0, 2, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_idle();
    t_multi_idle();
    t_timeout();
    t_boundary();
    t_halted();
    t_restart();
    t_zero_len();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule